// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous burst memory. When either of two address strobes is seen on a rising clock edge, it captures the external address as the base of a new four-word burst. On each later edge where the advance input is high, an internal two-bit counter steps and the two lowest address bits move to the next word of the burst. The upper address bits do not change until the next strobe.

The order of the four words is chosen at load time by an order-select input. In interleaved order the low bits are the base low bits XOR the counter. In linear order they are the base low bits plus the counter, wrapping modulo four. A burst can be paused by holding advance low. A strobe in the middle of a burst discards the old sequence and starts again from the new base. The storage array and the data path belong to the surrounding design.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high, and on the first edge after reset, `addr_out` is all zeros.
- R2: On an edge where `strobe_host`, `strobe_ctrl` or both are high, `addr_in` is captured and appears unchanged on `addr_out` after that edge. On edges with both strobes low, `addr_in` is ignored.
- R3: On an edge with both strobes low and `advance` low, `addr_out` keeps its value (suspend).
- R4: With interleaved order (`order_sel` = 1 at load), the low two bits after k advances are base[1:0] XOR (k mod 4).
- R5: With linear order (`order_sel` = 0 at load), the low two bits after k advances are (base[1:0] + k) mod 4.
- R6: Bits above bit 1 of `addr_out` change only on an edge with a strobe high.
- R7: After four advances the low bits return to the base low bits, and the sequence repeats.
- R8: When a strobe and `advance` are high on the same edge, the strobe wins: the new base is output with a counter of zero. This also applies in the middle of a burst.
- R9: `order_sel` is sampled only on a strobe edge. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_host | input | 1 | First address strobe, active high |
| strobe_ctrl | input | 1 | Second address strobe, active high |
| advance | input | 1 | Step the burst counter, active high |
| order_sel | input | 1 | Order of the new burst: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External base address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Every result takes effect on the edge that samples its stimulus. A load, a step or a hold is visible on `addr_out` exactly one clock edge after the inputs are applied. The bench drives inputs on the falling edge and updates its reference model on the following rising edge. It compares `addr_out` against the model on the next falling edge, so each comparison falls exactly one edge after the stimulus. The low bits and the upper bits are checked separately on every step, which keeps the sequence and upper-bit checks apart.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    // Width of the in-burst counter: four words per burst
    localparam int unsigned BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_ctr_next.sv
module burst_ctr_next #(
    parameter int unsigned CW = 2
) (
    input  logic          step_en,
    input  logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);
    // Natural wrap of the counter gives the four-word wrap
    always_comb begin
        cnt_d = cnt_q;
        if (step_en) begin
            cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/burst_lane_map.sv
module burst_lane_map
    import burst_seq_pkg::*;
#(
    parameter int unsigned CW = 2
) (
    input  logic [CW-1:0] base_lo,
    input  logic [CW-1:0] cnt,
    input  burst_order_e  order,
    output logic [CW-1:0] lane
);
    logic [CW-1:0] lane_ilv;
    logic [CW-1:0] lane_lin;

    // Interleaved order is a bitwise XOR: each lane bit is independent
    for (genvar i = 0; i < CW; i++) begin : g_xor
        assign lane_ilv[i] = base_lo[i] ^ cnt[i];
    end

    // Linear order is modular addition within the burst
    assign lane_lin = base_lo + cnt;

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: lane = lane_ilv;
            default:        lane = lane_lin;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_host,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int unsigned LO_W = BURST_W;
    localparam int unsigned HI_W = ADDR_W - LO_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LO_W-1:0]   cnt;
        burst_order_e      order;
    } seq_t;

    seq_t            st_d, st_q;
    logic            load;
    logic [LO_W-1:0] cnt_step;
    logic [LO_W-1:0] lane;

    assign load = strobe_host | strobe_ctrl;

    burst_ctr_next #(.CW(LO_W)) u_ctr (
        .step_en (advance),
        .cnt_q   (st_q.cnt),
        .cnt_d   (cnt_step)
    );

    // A load takes priority over a step on the same edge
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base  = addr_in;
            st_d.cnt   = '0;
            st_d.order = burst_order_e'(order_sel);
        end else begin
            st_d.cnt   = cnt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{base: '0, cnt: '0, order: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    burst_lane_map #(.CW(LO_W)) u_map (
        .base_lo (st_q.base[LO_W-1:0]),
        .cnt     (st_q.cnt),
        .order   (st_q.order),
        .lane    (lane)
    );

    assign addr_out = {st_q.base[ADDR_W-1:LO_W], lane};

    if (HI_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the burst counter width");
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_host,
    input logic              strobe_ctrl,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic ld;
    logic ilv_q;

    assign ld = strobe_host | strobe_ctrl;

    // Order of the burst in progress, as seen from the ports
    always_ff @(posedge clk) begin
        if (rst)     ilv_q <= 1'b0;
        else if (ld) ilv_q <= order_sel;
    end

    a_r2_load_base: assert property (@(posedge clk) disable iff (rst)
        ld |=> addr_out == $past(addr_in));

    a_r3_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !advance) |=> $stable(addr_out));

    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(addr_out[ADDR_W-1:2]));

    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && advance && !ilv_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

    a_r4_interleave_moves: assert property (@(posedge clk) disable iff (rst)
        (!ld && advance && ilv_q) |=> addr_out[1:0] != $past(addr_out[1:0]));

    a_r8_strobe_wins: assert property (@(posedge clk) disable iff (rst)
        (ld && advance) |=> addr_out == $past(addr_in));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int unsigned AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_host = 1'b0;
    logic          strobe_ctrl = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    bit            m_ilv = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .strobe_host(strobe_host), .strobe_ctrl(strobe_ctrl),
        .advance(advance), .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
    );

    task automatic check_val(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [1:0] lo;
        logic [AW-1:0] exp_full;
        if (m_ilv) lo = m_base[1:0] ^ 2'(m_cnt);
        else       lo = 2'((m_base[1:0] + 2'(m_cnt)) % 4);
        exp_full = {m_base[AW-1:2], lo};
        check_val(tag, {{(AW-2){1'b0}}, addr_out[1:0]}, {{(AW-2){1'b0}}, exp_full[1:0]});
        check_val("R6", {2'b00, addr_out[AW-1:2]}, {2'b00, exp_full[AW-1:2]});
    endtask

    task automatic step(input logic sh, input logic sc, input logic adv, input logic md,
                        input logic [AW-1:0] a, input string tag);
        strobe_host = sh;
        strobe_ctrl = sc;
        advance     = adv;
        order_sel   = md;
        addr_in     = a;
        @(posedge clk);
        if (sh || sc) begin
            m_base = a;
            m_ilv  = md;
            m_cnt  = 0;
        end else if (adv) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_val("R1", addr_out, '0);
        rst = 1'b0;
        // first edge out of reset with no strobe: still zero
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'hABCDE, "R1");

        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                string ordr;
                logic [AW-1:0] a;
                logic mdb;
                ordr = (md != 0) ? "R4" : "R5";
                mdb = (md != 0);
                a = AW'((md * 8 + s + 1) * 1237);
                a[1:0] = 2'(s);
                // load through one strobe or the other
                step(s[0], !s[0], 1'b0, mdb, a, "R2");
                // order_sel and addr_in toggled: must not matter
                step(1'b0, 1'b0, 1'b1, !mdb, ~a, "R9");
                step(1'b0, 1'b0, 1'b0, !mdb, ~a, "R3");
                step(1'b0, 1'b0, 1'b0, mdb, ~a, "R3");
                step(1'b0, 1'b0, 1'b1, !mdb, ~a, ordr);
                step(1'b0, 1'b0, 1'b1, mdb, a ^ 20'h00F0F, ordr);
                step(1'b0, 1'b0, 1'b1, !mdb, ~a, "R7");
                check_val("R7", addr_out, a);
                step(1'b0, 1'b0, 1'b1, mdb, ~a, ordr);
                // reload in the middle of a burst, together with advance
                step(1'b1, 1'b0, 1'b1, mdb, a ^ 20'h5A5A4, "R8");
                check_val("R8", addr_out, a ^ 20'h5A5A4);
                step(1'b0, 1'b0, 1'b1, mdb, a, ordr);
            end
        end

        // both strobes together
        step(1'b1, 1'b1, 1'b1, 1'b1, 20'h12347, "R2");
        check_val("R2", addr_out, 20'h12347);
        step(1'b0, 1'b0, 1'b1, 1'b0, 20'h0, "R4");
        step(1'b0, 1'b0, 1'b1, 1'b0, 20'h0, "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule